// File: doc/BRIEF.md
# Two-Wire Bus Start/Stop Condition Generator

This block is the condition generator at the front of a two-wire (I2C-style) bus controller. Software reaches it through a single 8-bit control word. It carries the bus enable, the interrupt enable, an acknowledge-policy bit, self-clearing START and STOP request bits, and a sticky interrupt flag. The block drives open-drain pull-down enables for SDA and SCL. From these it produces a START from an idle bus, a repeated START while it already owns the bus, and a STOP. Phase lengths are set by a fixed clock-divider tick.

A passive monitor watches the resolved bus lines. It decides whether another master currently holds the bus, so that a START request waits for a free bus. A byte engine outside this block reports each finished byte on `byte_done_i`, and that report makes a repeated START legal. Each completed condition or byte updates an 8-bit status code. Every status entry except the idle code raises the interrupt flag, and the flag is gated onto `irq_o` by the interrupt enable.

Top module: `twi_cond_gen`

## Requirements
- R1: The control word reads back as {irq_en[7], bus_en[6], start_req[5], stop_req[4], int_flag[3], ack_en[2], 2'b00}. A write loads irq_en, bus_en and ack_en directly from the same bit positions.
- R2: Writing 1 to bit 5 sets start_req, and writing 0 leaves it unchanged. The bit clears itself in the cycle that a START or repeated START completes.
- R3: Writing 1 to bit 4 sets stop_req. While the bus is owned, this produces a STOP and the bit clears when the STOP completes. Outside bus ownership the bit clears on the next clock with no bus activity.
- R4: When start_req=1, bus_en=1 and the bus is free, a START is issued: SDA falls while SCL is high, and SCL follows exactly CLK_DIV*PHASE_TICKS clocks later. The status becomes 0x08 and the block owns the bus, holding SCL low.
- R5: While the bus is owned, start_req produces a repeated START only after at least one `byte_done_i` since the last START. The status then becomes 0x10. A byte report sets the status to 0x28.
- R6: When start_req and stop_req are both set while the bus is owned, a STOP is sent first and then a fresh START (status 0x08).
- R7: `irq_o` equals int_flag AND irq_en, so it stays low whenever irq_en=0.
- R8: int_flag is set on entry to status 0x08, 0x10 or 0x28. It is not set on entry to idle status 0xF8, which follows reset and every STOP. Writing 1 to bit 3 clears it, and a set in the same cycle wins over the clear.
- R9: The bus counts as busy after a START is seen on the inputs, and as free after a STOP or reset. With bus_en=0 the inputs are ignored, the bus counts as free, and no sequence starts.
- R10: `master_o` is high from the first phase of a START until a STOP finishes. While it is low, both pull-down enables are off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 8 | Control word write data |
| rd_data_o | output | 8 | Control word read data |
| byte_done_i | input | 1 | One-cycle pulse from the byte engine: a byte finished |
| sda_i | input | 1 | Resolved SDA line |
| scl_i | input | 1 | Resolved SCL line |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| irq_o | output | 1 | Interrupt line |
| stat_o | output | 8 | Status code (0xF8, 0x08, 0x10, 0x28) |
| master_o | output | 1 | Block owns or is sequencing the bus |

## Verification
Two functions can land in the same cycle. A software write that clears the interrupt flag can coincide with a byte report that sets it. The bench provokes this by driving the clearing write and the `byte_done_i` pulse on the same clock edge while the block owns the bus. It then requires the flag to remain set with status 0x28. A second overlap, a combined START-and-STOP request, is judged from the order of the conditions seen on the wired-AND lines: a STOP followed by a START.

// File: rtl/twi_cg_pkg.sv
package twi_cg_pkg;
  localparam int B_IE   = 7;
  localparam int B_EN   = 6;
  localparam int B_STA  = 5;
  localparam int B_STO  = 4;
  localparam int B_FLAG = 3;
  localparam int B_ACK  = 2;

  localparam logic [7:0] ST_CODE_IDLE   = 8'hF8;
  localparam logic [7:0] ST_CODE_START  = 8'h08;
  localparam logic [7:0] ST_CODE_RSTART = 8'h10;
  localparam logic [7:0] ST_CODE_BYTE   = 8'h28;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_SETUP, SQ_HOLD, SQ_LOW, SQ_OWN,
    SQ_RS_REL, SQ_RS_SCLH, SQ_SP_LOW, SQ_SP_SCLH, SQ_SP_REL
  } seq_state_e;

  typedef struct packed {
    logic ie;
    logic en;
    logic sta;
    logic sto;
    logic flag;
    logic ack;
  } ctrl_t;

  typedef struct packed {
    logic start;
    logic rstart;
    logic stop;
    logic byt;
  } evt_t;
endpackage

// File: rtl/twi_cg_tick.sv
module twi_cg_tick #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CLK_DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_cnt
      localparam int W = $clog2(CLK_DIV);
      logic [W-1:0] cnt_q;
      assign tick_o = (cnt_q == W'(CLK_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/twi_cg_busmon.sv
module twi_cg_busmon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sda_i,
  input  logic scl_i,
  output logic bus_free_o
);
  logic sda_q, scl_q, busy_q;
  logic start_det, stop_det;

  assign start_det = en_i & scl_q & scl_i & sda_q & ~sda_i;
  assign stop_det  = en_i & scl_q & scl_i & ~sda_q & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q  <= 1'b1;
      scl_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      // keep sampling while disabled so enabling gives no false edge
      sda_q <= sda_i;
      scl_q <= scl_i;
      if (!en_i)          busy_q <= 1'b0;
      else if (start_det) busy_q <= 1'b1;
      else if (stop_det)  busy_q <= 1'b0;
    end
  end

  assign bus_free_o = ~busy_q;
endmodule

// File: rtl/twi_cg_regs.sv
module twi_cg_regs
  import twi_cg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  evt_t       evt_i,
  input  logic       sta_clr_i,
  input  logic       sto_clr_i,
  output ctrl_t      ctrl_o,
  output logic [7:0] stat_o,
  output logic [7:0] rd_data_o
);
  ctrl_t      ctrl_q;
  logic [7:0] stat_q;
  logic       flag_set;
  logic       unused_wr;

  assign unused_wr = ^wr_data_i[1:0];
  assign flag_set  = evt_i.start | evt_i.rstart | evt_i.byt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      stat_q <= ST_CODE_IDLE;
    end else begin
      if (wr_en_i) begin
        ctrl_q.ie  <= wr_data_i[B_IE];
        ctrl_q.en  <= wr_data_i[B_EN];
        ctrl_q.ack <= wr_data_i[B_ACK];
      end
      if (wr_en_i && wr_data_i[B_STA]) ctrl_q.sta <= 1'b1;
      else if (sta_clr_i)              ctrl_q.sta <= 1'b0;
      if (wr_en_i && wr_data_i[B_STO]) ctrl_q.sto <= 1'b1;
      else if (sto_clr_i)              ctrl_q.sto <= 1'b0;
      // new event wins over a clearing write
      if (flag_set)                          ctrl_q.flag <= 1'b1;
      else if (wr_en_i && wr_data_i[B_FLAG]) ctrl_q.flag <= 1'b0;
      if (evt_i.stop)        stat_q <= ST_CODE_IDLE;
      else if (evt_i.start)  stat_q <= ST_CODE_START;
      else if (evt_i.rstart) stat_q <= ST_CODE_RSTART;
      else if (evt_i.byt)    stat_q <= ST_CODE_BYTE;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign stat_o    = stat_q;
  assign rd_data_o = {ctrl_q.ie, ctrl_q.en, ctrl_q.sta, ctrl_q.sto,
                      ctrl_q.flag, ctrl_q.ack, 2'b00};
endmodule

// File: rtl/twi_cg_seq.sv
module twi_cg_seq
  import twi_cg_pkg::*;
#(
  parameter int PHASE_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic sta_i,
  input  logic sto_i,
  input  logic bus_free_i,
  input  logic byte_done_i,
  output evt_t evt_o,
  output logic sta_clr_o,
  output logic sto_clr_o,
  output logic sda_oe_o,
  output logic scl_oe_o,
  output logic master_o
);
  localparam int PH_W = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;

  seq_state_e  state_q, state_d;
  logic [PH_W-1:0] ph_q;
  logic        ph_done, rep_q, byte_seen_q;

  assign ph_done = tick_i && (ph_q == PH_W'(PHASE_TICKS - 1));

  always_comb begin
    state_d = state_q;
    evt_o   = '0;
    unique case (state_q)
      SQ_IDLE:    if (en_i && sta_i && bus_free_i) state_d = SQ_SETUP;
      SQ_SETUP:   if (ph_done) state_d = SQ_HOLD;
      SQ_HOLD:    if (ph_done) state_d = SQ_LOW;
      SQ_LOW: if (ph_done) begin
        state_d      = SQ_OWN;
        evt_o.start  = ~rep_q;
        evt_o.rstart = rep_q;
      end
      SQ_OWN: begin
        evt_o.byt = byte_done_i;
        if (sto_i)                    state_d = SQ_SP_LOW;
        else if (sta_i && byte_seen_q) state_d = SQ_RS_REL;
      end
      SQ_RS_REL:  if (ph_done) state_d = SQ_RS_SCLH;
      SQ_RS_SCLH: if (ph_done) state_d = SQ_HOLD;
      SQ_SP_LOW:  if (ph_done) state_d = SQ_SP_SCLH;
      SQ_SP_SCLH: if (ph_done) state_d = SQ_SP_REL;
      SQ_SP_REL: if (ph_done) begin
        state_d    = SQ_IDLE;
        evt_o.stop = 1'b1;
      end
      default:    state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SQ_IDLE;
      ph_q        <= '0;
      rep_q       <= 1'b0;
      byte_seen_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q)  ph_q <= '0;
      else if (tick_i)         ph_q <= ph_q + 1'b1;
      if (state_d == SQ_RS_REL)     rep_q <= 1'b1;
      else if (state_d == SQ_SETUP) rep_q <= 1'b0;
      if (evt_o.start || evt_o.rstart) byte_seen_q <= 1'b0;
      else if (evt_o.byt)              byte_seen_q <= 1'b1;
    end
  end

  assign sta_clr_o = evt_o.start | evt_o.rstart;
  assign sto_clr_o = evt_o.stop | ((state_q == SQ_IDLE) & sto_i);
  assign master_o  = (state_q != SQ_IDLE);

  always_comb begin
    sda_oe_o = 1'b0;
    scl_oe_o = 1'b0;
    unique case (state_q)
      SQ_HOLD:                begin sda_oe_o = 1'b1; end
      SQ_LOW, SQ_SP_LOW:      begin sda_oe_o = 1'b1; scl_oe_o = 1'b1; end
      SQ_OWN, SQ_RS_REL:      begin scl_oe_o = 1'b1; end
      SQ_SP_SCLH:             begin sda_oe_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/twi_cond_gen.sv
module twi_cond_gen
  import twi_cg_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int PHASE_TICKS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       byte_done_i,
  input  logic       sda_i,
  input  logic       scl_i,
  output logic       sda_oe_o,
  output logic       scl_oe_o,
  output logic       irq_o,
  output logic [7:0] stat_o,
  output logic       master_o
);
  ctrl_t ctrl;
  evt_t  evt;
  logic  tick, bus_free, sta_clr, sto_clr;

  twi_cg_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_o (tick)
  );

  twi_cg_busmon u_mon (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (ctrl.en),
    .sda_i (sda_i), .scl_i (scl_i), .bus_free_o (bus_free)
  );

  twi_cg_regs u_regs (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_en_i (wr_en_i), .wr_data_i (wr_data_i),
    .evt_i (evt), .sta_clr_i (sta_clr), .sto_clr_i (sto_clr),
    .ctrl_o (ctrl), .stat_o (stat_o), .rd_data_o (rd_data_o)
  );

  twi_cg_seq #(.PHASE_TICKS(PHASE_TICKS)) u_seq (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick), .en_i (ctrl.en),
    .sta_i (ctrl.sta), .sto_i (ctrl.sto), .bus_free_i (bus_free),
    .byte_done_i (byte_done_i), .evt_o (evt), .sta_clr_o (sta_clr),
    .sto_clr_o (sto_clr), .sda_oe_o (sda_oe_o), .scl_oe_o (scl_oe_o),
    .master_o (master_o)
  );

  assign irq_o = ctrl.flag & ctrl.ie;
endmodule

// File: rtl/twi_cond_gen_chk.sv
module twi_cond_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       sda_oe_o,
  input logic       scl_oe_o,
  input logic       irq_o,
  input logic [7:0] stat_o,
  input logic       master_o
);
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[7] |-> !irq_o); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rd_data_o[3]); // R7
  AST_STA_CLR_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_data_o[5]) |-> (stat_o == 8'h08 || stat_o == 8'h10)); // R2
  AST_FLAG_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[3]) |-> stat_o != 8'hF8); // R8
  AST_RELEASED_OFF_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_o |-> (!sda_oe_o && !scl_oe_o)); // R10
  AST_START_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(master_o) |-> $past(rd_data_o[6])); // R4
  AST_STO_IDLE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[4] && !master_o && !(wr_en_i && wr_data_i[4])) |=> !rd_data_o[4]); // R3
endmodule

bind twi_cond_gen twi_cond_gen_chk u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .wr_en_i (wr_en_i), .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o), .sda_oe_o (sda_oe_o), .scl_oe_o (scl_oe_o),
  .irq_o (irq_o), .stat_o (stat_o), .master_o (master_o)
);

// File: tb/sim_twi_cond_gen.sv
`timescale 1ns/1ps
module sim_twi_cond_gen;
  localparam int DIV = 4;
  localparam int PH  = 2;
  localparam longint HOLD_NS = DIV * PH * 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       byte_done = 1'b0;
  logic       ext_sda = 1'b0, ext_scl = 1'b0;
  logic [7:0] rd_data, stat;
  logic       sda_oe, scl_oe, irq, master;
  wire        sda_w = ~(sda_oe | ext_sda);
  wire        scl_w = ~(scl_oe | ext_scl);

  twi_cond_gen #(.CLK_DIV(DIV), .PHASE_TICKS(PH)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .wr_data_i (wr_data),
    .rd_data_o (rd_data), .byte_done_i (byte_done), .sda_i (sda_w), .scl_i (scl_w),
    .sda_oe_o (sda_oe), .scl_oe_o (scl_oe), .irq_o (irq), .stat_o (stat),
    .master_o (master)
  );

  int n_run = 0, n_fail = 0;
  int n_s = 0, n_p = 0;
  logic [3:0] hist = '0;
  longint t_sfall = 0, hold_ns = 0;

  always @(negedge sda_w) if (rst_n && scl_w === 1'b1) begin
    n_s++; hist = {hist[1:0], 2'd1}; t_sfall = longint'($time);
  end
  always @(posedge sda_w) if (rst_n && scl_w === 1'b1) begin
    n_p++; hist = {hist[1:0], 2'd2};
  end
  always @(negedge scl_w) if (rst_n) hold_ns = longint'($time) - t_sfall;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_stat(input logic [7:0] code, input int lim);
    for (int i = 0; i < lim && stat !== code; i++) @(negedge clk);
  endtask

  task automatic wait_master(input logic want, input int lim);
    for (int i = 0; i < lim && master !== want; i++) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int s0, p0;
    do_reset();
    // reset state
    chk(rd_data == 8'h00, "R1 reset word", rd_data, 8'h00);
    chk(stat == 8'hF8, "R8 reset status", stat, 8'hF8);
    chk(!sda_oe && !scl_oe && !master && !irq, "R10 reset outputs",
        {sda_oe, scl_oe, master, irq}, 0);

    // sweep of every write with bus disabled
    for (int v = 0; v < 256; v++) begin
      if (v[6]) continue;
      do_reset();
      wr(8'(v));
      @(negedge clk);
      chk(rd_data == (8'(v) & 8'hA4), "R1 R3 write/readback", rd_data, 8'(v) & 8'hA4);
      chk(!irq && !sda_oe && !scl_oe && !master && n_p == 0 && n_s == 0,
          "R9 R7 disabled quiet", {irq, sda_oe, scl_oe, master}, 0);
      wr(8'h00);
      chk(rd_data == (8'(v) & 8'h20), "R2 zero write keeps start_req", rd_data, 8'(v) & 8'h20);
    end

    // START from idle
    do_reset();
    wr(8'hE0);
    wait_stat(8'h08, 200);
    chk(n_s == 1 && n_p == 0, "R4 one START", n_s, 1);
    chk(rd_data == 8'hC8, "R2 R8 start_req cleared, flag set", rd_data, 8'hC8);
    chk(irq == 1'b1, "R7 irq with enable", irq, 1);
    chk(scl_oe && !sda_oe && master, "R4 owns bus, SCL held", {scl_oe, sda_oe, master}, 3'b101);
    chk(hold_ns == HOLD_NS, "R4 START hold time", hold_ns, HOLD_NS);
    wr(8'hC8);
    chk(rd_data == 8'hC0 && !irq, "R8 write-1 clears flag", rd_data, 8'hC0);

    // repeated START gated by a byte
    wr(8'hE0);
    repeat (150) @(negedge clk);
    chk(n_s == 1 && rd_data[5] && stat == 8'h08, "R5 no repeated START before byte", n_s, 1);
    byte_done = 1'b1; @(negedge clk); byte_done = 1'b0;
    chk(stat == 8'h28 && rd_data[3], "R5 R8 byte status and flag", stat, 8'h28);
    wait_stat(8'h10, 200);
    chk(n_s == 2 && n_p == 0, "R5 repeated START seen", n_s, 2);
    chk(rd_data == 8'hC8, "R2 start_req cleared after repeat", rd_data, 8'hC8);
    chk(hold_ns == HOLD_NS, "R5 repeated START hold", hold_ns, HOLD_NS);

    // flag clear colliding with a byte report
    wr(8'hC8);
    chk(!rd_data[3], "R8 flag cleared", rd_data, 8'hC0);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hC8; byte_done = 1'b1;
    @(negedge clk); wr_en = 1'b0; byte_done = 1'b0;
    chk(rd_data[3] && stat == 8'h28, "R8 set wins over clear", {rd_data, stat}, 16'hC828);

    // both requests in master mode, irq disabled
    s0 = n_s; p0 = n_p;
    wr(8'h78);
    wait_stat(8'hF8, 200);
    wait_stat(8'h08, 200);
    chk(hist == 4'b1001 && n_s == s0 + 1 && n_p == p0 + 1, "R6 STOP then START", hist, 4'b1001);
    chk(rd_data == 8'h48 && !irq, "R7 R6 flag set, irq off", {rd_data, irq}, 9'h090);

    // STOP; idle status must not set the flag
    p0 = n_p;
    wr(8'hD8);
    wait_stat(8'hF8, 200);
    wait_master(1'b0, 50);
    chk(n_p == p0 + 1 && !master, "R3 STOP sent", n_p, p0 + 1);
    chk(rd_data == 8'hC0 && !irq, "R8 no flag on idle status", rd_data, 8'hC0);
    chk(!sda_oe && !scl_oe, "R10 lines released", {sda_oe, scl_oe}, 0);

    // stop request while not owning the bus
    p0 = n_p;
    wr(8'h50);
    @(negedge clk);
    chk(rd_data == 8'h40 && n_p == p0 && !master, "R3 idle stop clears, no bus", rd_data, 8'h40);

    // another master holds the bus
    s0 = n_s;
    ext_sda = 1'b1; repeat (3) @(negedge clk);
    wr(8'hE0);
    repeat (150) @(negedge clk);
    chk(!master && rd_data[5] && !sda_oe && !scl_oe, "R9 R4 waits while busy",
        {master, rd_data[5]}, 2'b01);
    ext_sda = 1'b0;
    wait_stat(8'h08, 200);
    chk(master && n_s == s0 + 2, "R9 START after foreign STOP", n_s, s0 + 2);
    wr(8'hD8);
    wait_master(1'b0, 200);

    // disabled monitor ignores a START with no STOP
    wr(8'h00);
    ext_sda = 1'b1; repeat (2) @(negedge clk);
    ext_scl = 1'b1; repeat (2) @(negedge clk);
    ext_sda = 1'b0; repeat (2) @(negedge clk);
    ext_scl = 1'b0; repeat (2) @(negedge clk);
    wr(8'h60);
    wait_stat(8'h08, 200);
    chk(master && stat == 8'h08, "R9 inputs ignored while disabled", stat, 8'h08);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule